// File: doc/BRIEF.md
# Ethernet PHY Bring-Up and Link Report Sequencer

This block sits in front of a management-bus frame master and drives it, one register transaction at a time, to bring an Ethernet transceiver into service. A start request first proves the management wiring: a known word goes into a scratch register twice and is read back. A mismatch ends the run with a fault. A good echo is followed by three setup writes: general configuration, the auto-negotiation advertisement (100 Mb/s or 10 Mb/s half duplex, picked at start), and a control word that enables and restarts negotiation. The block then polls a chip status register until it reports link or a retry limit runs out.

Speed and duplex are decoded from three bits of the last status read into a small link code, and a one-cycle done pulse marks every finished sequence. A PHY interrupt request runs the clearing reads in their required order before it polls the link again. A separate request writes the interrupt enable register. The frame master takes a request that is held while `reqValid` is high and answers with a one-cycle `reqDone`. Read data is valid in that same cycle.

Top module: `phy_link_seq`

## Requirements
- R1: After reset `linkCode` is 0 (no link), `linkFault` is 0, `done` is 0 and `reqValid` is 0.
- R2: A start issues two writes of `TEST_WORD` to `SCRATCH_REG` and then one read of it. If the returned word differs, the sequence ends with `linkFault`=1, `linkCode`=7, and no further requests.
- R3: After a good echo the block issues these writes in this order: `CFG_REG`=0x0000, then register 4 = 0x0081 if `speed100` was high at start (0x0021 if it was low), then register 0 = 0x1300.
- R4: The link poll reads `CHIP_REG` at most `POLL_MAX` times. At least `POLL_WAIT` idle cycles come before each read. The poll stops after the first read that has bit 9 set.
- R5: The link code is taken from bits 13:11 of the last poll read. 3'b111 gives 4 (100 full), 3'b101 gives 3 (100 half), 3'b110 gives 2 (10 full), 3'b100 gives 1 (10 half), and any other value gives 0 (no link).
- R6: `done` is high for exactly one cycle, the cycle after the final response. `linkCode` and `linkFault` are already updated in that cycle.
- R7: An interrupt request reads register 1 and then `ISR_REG`, and then runs the poll and decode of R4 and R5.
- R8: An enable request writes 0x0002 (`ienVal`=1) or 0x0000 (`ienVal`=0) to `IEN_REG` and pulses `done`. `linkCode` and `linkFault` do not change.
- R9: Start, interrupt and enable requests are ignored while a sequence runs. In idle, when several arrive together, start wins over interrupt, and interrupt wins over enable.
- R10: `reqValid` and the request fields stay stable from the time a request is raised until `reqDone`.
- R11: Every request carries `reqPhy` = `PHY_ADDR`.
- R12: A completed link report clears `linkFault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin bring-up |
| speed100 | input | 1 | Advertise 100 Mb/s half duplex (sampled at start) |
| irqReq | input | 1 | Service a PHY interrupt |
| ienReq | input | 1 | Write the interrupt enable register |
| ienVal | input | 1 | Enable (1) or disable (0) value for `ienReq` |
| reqValid | output | 1 | Transaction request to the frame master |
| reqWrite | output | 1 | 1 = write, 0 = read |
| reqPhy | output | 5 | PHY address |
| reqReg | output | 5 | Register address |
| reqData | output | 16 | Write data |
| reqDone | input | 1 | Transaction complete (one cycle) |
| rdData | input | 16 | Read data, valid with `reqDone` |
| linkCode | output | 3 | 0 none, 1 10H, 2 10F, 3 100H, 4 100F, 7 fault |
| linkFault | output | 1 | Echo check failed on last bring-up |
| done | output | 1 | Sequence finished pulse |

## Verification
The bench corrupts one bit of the echoed scratch word. A design that skipped or mis-compared the check would go on to configure the PHY, and would show too many transactions and no fault. It makes the link appear on the first read, on a later read, and never. Wrong loop bounds would show up as a wrong read count, either running past the limit or polling again after link came up. It also feeds status values with bit 13 clear and the other field bits set, which a decoder that tests bits one at a time would report as a link. It raises start and interrupt together and during a run, where a design with a wrong priority or a missing busy guard would interleave register-1 reads or restart bring-up.

// File: rtl/phy_link_seq_pkg.sv
package phy_link_seq_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_MIR_WR, OP_MIR_RD, OP_CFG_WR, OP_ADV_WR, OP_CTL_WR,
    OP_BSR_RD, OP_ISR_RD, OP_CHIP_RD, OP_IEN_WR
  } mgmtOp_e;

  typedef enum logic [2:0] {
    LINK_NONE  = 3'd0,
    LINK_10H   = 3'd1,
    LINK_10F   = 3'd2,
    LINK_100H  = 3'd3,
    LINK_100F  = 3'd4,
    LINK_FAULT = 3'd7
  } linkCode_e;

  typedef struct packed {
    logic    issue;
    mgmtOp_e op;
    logic    takeCmd;
    logic    clrPoll;
    logic    incPoll;
    logic    loadWait;
    logic    tickWait;
    logic    finLink;
    logic    finFault;
    logic    finQuiet;
  } seqCtl_t;

  typedef struct packed {
    logic waitZero;
    logic pollLast;
    logic linkUp;
    logic echoOk;
  } seqSts_t;

endpackage

// File: rtl/phy_link_seq_ctrl.sv
module phy_link_seq_ctrl
  import phy_link_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    irqReq,
  input  logic    ienReq,
  input  logic    reqDone,
  input  seqSts_t sts,
  output seqCtl_t ctl
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_MIR_WR1, ST_MIR_WR2, ST_MIR_RD, ST_CFG, ST_ADV, ST_CTL,
    ST_BSR, ST_ISR, ST_WAIT, ST_POLL, ST_IEN
  } seqState_e;

  seqState_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctl.takeCmd = 1'b1;
          nxt = ST_MIR_WR1;
        end else if (irqReq) begin
          nxt = ST_BSR;
        end else if (ienReq) begin
          ctl.takeCmd = 1'b1;
          nxt = ST_IEN;
        end
      end
      ST_MIR_WR1: begin
        ctl.issue = 1'b1; ctl.op = OP_MIR_WR;
        if (reqDone) nxt = ST_MIR_WR2;
      end
      ST_MIR_WR2: begin
        ctl.issue = 1'b1; ctl.op = OP_MIR_WR;
        if (reqDone) nxt = ST_MIR_RD;
      end
      ST_MIR_RD: begin
        ctl.issue = 1'b1; ctl.op = OP_MIR_RD;
        if (reqDone) begin
          if (sts.echoOk) nxt = ST_CFG;
          else begin
            ctl.finFault = 1'b1;
            nxt = ST_IDLE;
          end
        end
      end
      ST_CFG: begin
        ctl.issue = 1'b1; ctl.op = OP_CFG_WR;
        if (reqDone) nxt = ST_ADV;
      end
      ST_ADV: begin
        ctl.issue = 1'b1; ctl.op = OP_ADV_WR;
        if (reqDone) nxt = ST_CTL;
      end
      ST_CTL: begin
        ctl.issue = 1'b1; ctl.op = OP_CTL_WR;
        if (reqDone) begin
          ctl.clrPoll = 1'b1; ctl.loadWait = 1'b1;
          nxt = ST_WAIT;
        end
      end
      ST_BSR: begin
        ctl.issue = 1'b1; ctl.op = OP_BSR_RD;
        if (reqDone) nxt = ST_ISR;
      end
      ST_ISR: begin
        ctl.issue = 1'b1; ctl.op = OP_ISR_RD;
        if (reqDone) begin
          ctl.clrPoll = 1'b1; ctl.loadWait = 1'b1;
          nxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        ctl.tickWait = 1'b1;
        if (sts.waitZero) nxt = ST_POLL;
      end
      ST_POLL: begin
        ctl.issue = 1'b1; ctl.op = OP_CHIP_RD;
        if (reqDone) begin
          if (sts.linkUp || sts.pollLast) begin
            ctl.finLink = 1'b1;
            nxt = ST_IDLE;
          end else begin
            ctl.incPoll = 1'b1; ctl.loadWait = 1'b1;
            nxt = ST_WAIT;
          end
        end
      end
      ST_IEN: begin
        ctl.issue = 1'b1; ctl.op = OP_IEN_WR;
        if (reqDone) begin
          ctl.finQuiet = 1'b1;
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // R10: an outstanding request keeps its operation until answered
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && !reqDone) |=> (ctl.issue && $stable(ctl.op)));

  // R9: a request pin seen mid-sequence never sends the FSM back to idle early
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !sts.waitZero && (startReq || irqReq)) |=> (state == ST_WAIT));

endmodule

// File: rtl/phy_link_seq_dp.sv
module phy_link_seq_dp
  import phy_link_seq_pkg::*;
#(
  parameter logic [4:0]  PHY_ADDR    = 5'd0,
  parameter logic [4:0]  CTRL_REG    = 5'd0,
  parameter logic [4:0]  STAT_REG    = 5'd1,
  parameter logic [4:0]  ADV_REG     = 5'd4,
  parameter logic [4:0]  SCRATCH_REG = 5'd16,
  parameter logic [4:0]  IEN_REG     = 5'd17,
  parameter logic [4:0]  ISR_REG     = 5'd18,
  parameter logic [4:0]  CFG_REG     = 5'd19,
  parameter logic [4:0]  CHIP_REG    = 5'd20,
  parameter logic [15:0] TEST_WORD   = 16'h6c93,
  parameter int          POLL_WAIT   = 1000,
  parameter int          POLL_MAX    = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqCtl_t     ctl,
  input  logic        speed100,
  input  logic        ienVal,
  input  logic        reqDone,
  input  logic [15:0] rdData,
  output seqSts_t     sts,
  output logic        reqValid,
  output logic        reqWrite,
  output logic [4:0]  reqPhy,
  output logic [4:0]  reqReg,
  output logic [15:0] reqData,
  output logic [2:0]  linkCode,
  output logic        linkFault,
  output logic        done
);

  localparam int WAIT_W = $clog2(POLL_WAIT + 1);
  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [15:0] CFG_WORD   = 16'h0000;
  localparam logic [15:0] ADV_100H   = 16'h0081;
  localparam logic [15:0] ADV_10H    = 16'h0021;
  localparam logic [15:0] CTRL_WORD  = 16'h1300;
  localparam logic [15:0] IEN_ON     = 16'h0002;
  localparam int          LINK_BIT   = 9;

  logic              speedSel, ienSel;
  logic [WAIT_W-1:0] waitCnt;
  logic [POLL_W-1:0] pollCnt;
  linkCode_e         codeQ;

  function automatic linkCode_e decodeLink(input logic [2:0] fld);
    unique case (fld)
      3'b111:  return LINK_100F;
      3'b101:  return LINK_100H;
      3'b110:  return LINK_10F;
      3'b100:  return LINK_10H;
      default: return LINK_NONE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      speedSel  <= 1'b0;
      ienSel    <= 1'b0;
      waitCnt   <= '0;
      pollCnt   <= '0;
      codeQ     <= LINK_NONE;
      linkFault <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (ctl.takeCmd) begin
        speedSel <= speed100;
        ienSel   <= ienVal;
      end
      if (ctl.loadWait)                       waitCnt <= WAIT_W'(POLL_WAIT);
      else if (ctl.tickWait && waitCnt != '0) waitCnt <= waitCnt - 1'b1;
      if (ctl.clrPoll)      pollCnt <= '0;
      else if (ctl.incPoll) pollCnt <= pollCnt + 1'b1;
      done <= ctl.finLink | ctl.finFault | ctl.finQuiet;
      if (ctl.finFault) begin
        linkFault <= 1'b1;
        codeQ     <= LINK_FAULT;
      end else if (ctl.finLink) begin
        linkFault <= 1'b0;
        codeQ     <= decodeLink(rdData[13:11]);
      end
    end
  end

  always_comb begin
    reqWrite = 1'b0;
    reqReg   = CTRL_REG;
    reqData  = '0;
    unique case (ctl.op)
      OP_MIR_WR:  begin reqWrite = 1'b1; reqReg = SCRATCH_REG; reqData = TEST_WORD; end
      OP_MIR_RD:  reqReg = SCRATCH_REG;
      OP_CFG_WR:  begin reqWrite = 1'b1; reqReg = CFG_REG; reqData = CFG_WORD; end
      OP_ADV_WR:  begin reqWrite = 1'b1; reqReg = ADV_REG; reqData = speedSel ? ADV_100H : ADV_10H; end
      OP_CTL_WR:  begin reqWrite = 1'b1; reqReg = CTRL_REG; reqData = CTRL_WORD; end
      OP_BSR_RD:  reqReg = STAT_REG;
      OP_ISR_RD:  reqReg = ISR_REG;
      OP_CHIP_RD: reqReg = CHIP_REG;
      OP_IEN_WR:  begin reqWrite = 1'b1; reqReg = IEN_REG; reqData = ienSel ? IEN_ON : 16'h0000; end
      default:    reqReg = CTRL_REG;
    endcase
  end

  assign reqValid     = ctl.issue;
  assign reqPhy       = PHY_ADDR;
  assign linkCode     = codeQ;
  assign sts.waitZero = (waitCnt == '0);
  assign sts.pollLast = (pollCnt == POLL_W'(POLL_MAX - 1));
  assign sts.linkUp   = rdData[LINK_BIT];
  assign sts.echoOk   = (rdData == TEST_WORD);

  // R4: the retry counter never reaches the limit
  p_poll_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_MAX));

  // R2: a raised fault flag always comes with the fault code
  p_fault_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    linkFault |-> (linkCode == 3'd7));

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: an enable-only sequence leaves the link report untouched
  p_quiet_keeps_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finQuiet |=> ($stable(linkCode) && $stable(linkFault)));

endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_link_seq_pkg::*;
#(
  parameter logic [4:0]  PHY_ADDR    = 5'd0,
  parameter logic [4:0]  CTRL_REG    = 5'd0,
  parameter logic [4:0]  STAT_REG    = 5'd1,
  parameter logic [4:0]  ADV_REG     = 5'd4,
  parameter logic [4:0]  SCRATCH_REG = 5'd16,
  parameter logic [4:0]  IEN_REG     = 5'd17,
  parameter logic [4:0]  ISR_REG     = 5'd18,
  parameter logic [4:0]  CFG_REG     = 5'd19,
  parameter logic [4:0]  CHIP_REG    = 5'd20,
  parameter logic [15:0] TEST_WORD   = 16'h6c93,
  parameter int          POLL_WAIT   = 1000,
  parameter int          POLL_MAX    = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        speed100,
  input  logic        irqReq,
  input  logic        ienReq,
  input  logic        ienVal,
  output logic        reqValid,
  output logic        reqWrite,
  output logic [4:0]  reqPhy,
  output logic [4:0]  reqReg,
  output logic [15:0] reqData,
  input  logic        reqDone,
  input  logic [15:0] rdData,
  output logic [2:0]  linkCode,
  output logic        linkFault,
  output logic        done
);

  seqCtl_t ctl;
  seqSts_t sts;

  phy_link_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .irqReq   (irqReq),
    .ienReq   (ienReq),
    .reqDone  (reqDone),
    .sts      (sts),
    .ctl      (ctl)
  );

  phy_link_seq_dp #(
    .PHY_ADDR(PHY_ADDR), .CTRL_REG(CTRL_REG), .STAT_REG(STAT_REG), .ADV_REG(ADV_REG),
    .SCRATCH_REG(SCRATCH_REG), .IEN_REG(IEN_REG), .ISR_REG(ISR_REG), .CFG_REG(CFG_REG),
    .CHIP_REG(CHIP_REG), .TEST_WORD(TEST_WORD), .POLL_WAIT(POLL_WAIT), .POLL_MAX(POLL_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .speed100  (speed100),
    .ienVal    (ienVal),
    .reqDone   (reqDone),
    .rdData    (rdData),
    .sts       (sts),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqPhy    (reqPhy),
    .reqReg    (reqReg),
    .reqData   (reqData),
    .linkCode  (linkCode),
    .linkFault (linkFault),
    .done      (done)
  );

endmodule

// File: tb/phy_link_seq_test.sv
module phy_link_seq_test;

  localparam int          WAITC = 8;
  localparam int          PMAX  = 50;
  localparam int          LAT   = 3;
  localparam logic [15:0] TW    = 16'hA55A;
  localparam logic [4:0]  PADDR = 5'd3;

  logic clk = 0, rstN = 0;
  logic startReq = 0, speed100 = 0, irqReq = 0, ienReq = 0, ienVal = 0;
  logic reqDone = 0;
  logic [15:0] rdData = 0;
  logic reqValid, reqWrite, linkFault, done;
  logic [4:0] reqPhy, reqReg;
  logic [15:0] reqData;
  logic [2:0] linkCode;

  phy_link_seq #(.PHY_ADDR(PADDR), .TEST_WORD(TW), .POLL_WAIT(WAITC), .POLL_MAX(PMAX)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .speed100(speed100), .irqReq(irqReq),
    .ienReq(ienReq), .ienVal(ienVal), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPhy(reqPhy), .reqReg(reqReg), .reqData(reqData), .reqDone(reqDone),
    .rdData(rdData), .linkCode(linkCode), .linkFault(linkFault), .done(done));

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;

  // frame master model
  logic mBusy = 0;
  int mCnt = 0;
  logic [15:0] mResp = 0, scratch = 0, corrupt = 0, chipVal = 0;
  int chipReads = 0, linkAt = 0, holdErr = 0, logN = 0;
  logic lW = 0;
  logic [4:0] lReg = 0;
  logic [15:0] lData = 0;
  logic logW[256];
  logic [4:0] logReg[256], logPhy[256];
  logic [15:0] logData[256];
  int logCyc[256];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    reqDone <= 1'b0;
    if (mBusy) begin
      if (reqValid !== 1'b1 || reqWrite !== lW || reqReg !== lReg || reqData !== lData)
        holdErr <= holdErr + 1;
      if (mCnt == 1) begin
        mBusy <= 1'b0; reqDone <= 1'b1; rdData <= mResp;
      end
      mCnt <= mCnt - 1;
    end else if (rstN && reqValid && !reqDone) begin
      mBusy <= 1'b1; mCnt <= LAT;
      lW <= reqWrite; lReg <= reqReg; lData <= reqData;
      logW[logN] <= reqWrite; logReg[logN] <= reqReg; logPhy[logN] <= reqPhy;
      logData[logN] <= reqData; logCyc[logN] <= cyc;
      logN <= logN + 1;
      if (reqWrite) begin
        if (reqReg == 5'd16) scratch <= reqData;
        mResp <= 16'h0;
      end else if (reqReg == 5'd16) mResp <= scratch ^ corrupt;
      else if (reqReg == 5'd20) begin
        mResp <= (chipReads >= linkAt) ? (chipVal | 16'h0200) : (chipVal & ~16'h0200);
        chipReads <= chipReads + 1;
      end else mResp <= 16'h0;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit entryOk(int i, logic w, logic [4:0] r, logic [15:0] d);
    return logW[i] == w && logReg[i] == r && (!w || logData[i] == d) && logPhy[i] == PADDR;
  endfunction

  task automatic waitDone(string tag);
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
    chk(tag, "done width one cycle (R6)", done, 0);
  endtask

  task automatic pulseStart();
    @(negedge clk) startReq = 1;
    @(negedge clk) startReq = 0;
  endtask

  task automatic checkPolls(string tag, int first, int n);
    for (int k = 0; k < n; k++) begin
      chk(tag, $sformatf("poll read %0d (R4,R11)", k), entryOk(first + k, 0, 5'd20, 0), 1);
      if (k > 0)
        chk(tag, "poll spacing (R4)",
            (logCyc[first + k] - logCyc[first + k - 1]) >= (WAITC + LAT + 1), 1);
    end
  endtask

  task automatic t_reset();
    chk("R1", "linkCode", linkCode, 0);
    chk("R1", "linkFault", linkFault, 0);
    chk("R1", "done", done, 0);
    chk("R1", "reqValid", reqValid, 0);
  endtask

  // R2 R3 R4 R5 R6 R11 R12
  task automatic t_bringup(string tag, logic sp, int lnk, logic [15:0] chv, int expCode, int expPolls);
    int base;
    base = logN; linkAt = chipReads + lnk; chipVal = chv; speed100 = sp;
    pulseStart();
    speed100 = ~sp;
    while (done !== 1'b1) @(negedge clk);
    chk(tag, "linkCode (R5)", linkCode, expCode);
    chk(tag, "linkFault cleared (R12)", linkFault, 0);
    @(negedge clk);
    chk(tag, "done width one cycle (R6)", done, 0);
    chk(tag, "transaction count (R4)", logN - base, 6 + expPolls);
    chk(tag, "scratch write 1 (R2)", entryOk(base, 1, 5'd16, TW), 1);
    chk(tag, "scratch write 2 (R2)", entryOk(base + 1, 1, 5'd16, TW), 1);
    chk(tag, "scratch read (R2)", entryOk(base + 2, 0, 5'd16, 0), 1);
    chk(tag, "config write (R3)", entryOk(base + 3, 1, 5'd19, 16'h0000), 1);
    chk(tag, "advert write (R3)", entryOk(base + 4, 1, 5'd4, sp ? 16'h0081 : 16'h0021), 1);
    chk(tag, "control write (R3)", entryOk(base + 5, 1, 5'd0, 16'h1300), 1);
    checkPolls(tag, base + 6, expPolls);
  endtask

  task automatic t_fault();
    int base;
    base = logN; corrupt = 16'h0100;
    pulseStart();
    while (done !== 1'b1) @(negedge clk);
    chk("R2", "fault code", linkCode, 7);
    chk("R2", "fault flag", linkFault, 1);
    repeat (20) @(negedge clk);
    chk("R2", "stop after bad echo", logN - base, 3);
    corrupt = 16'h0;
  endtask

  task automatic t_irq(int lnk, logic [15:0] chv, int expCode);
    int base;
    base = logN; linkAt = chipReads + lnk; chipVal = chv;
    @(negedge clk) irqReq = 1;
    @(negedge clk) irqReq = 0;
    while (done !== 1'b1) @(negedge clk);
    chk("R7", "linkCode after irq", linkCode, expCode);
    chk("R7", "count", logN - base, 2 + lnk + 1);
    chk("R7", "status read first", entryOk(base, 0, 5'd1, 0), 1);
    chk("R7", "int status read second", entryOk(base + 1, 0, 5'd18, 0), 1);
    checkPolls("R7", base + 2, lnk + 1);
    @(negedge clk);
  endtask

  task automatic t_ien(logic v);
    int base; logic [2:0] codeBefore; logic faultBefore;
    base = logN; codeBefore = linkCode; faultBefore = linkFault;
    @(negedge clk) begin ienReq = 1; ienVal = v; end
    @(negedge clk) begin ienReq = 0; ienVal = ~v; end
    waitDone("R8");
    chk("R8", "one write", logN - base, 1);
    chk("R8", "enable write", entryOk(base, 1, 5'd17, v ? 16'h0002 : 16'h0000), 1);
    chk("R8", "linkCode kept", linkCode, codeBefore);
    chk("R8", "linkFault kept", linkFault, faultBefore);
  endtask

  task automatic t_busy();
    int base;
    base = logN; linkAt = chipReads + 1; chipVal = 16'h2800;
    @(negedge clk) begin startReq = 1; irqReq = 1; ienReq = 1; end
    @(negedge clk) begin startReq = 0; irqReq = 0; ienReq = 0; end
    repeat (5) @(negedge clk);
    @(negedge clk) begin startReq = 1; irqReq = 1; ienReq = 1; end
    @(negedge clk) begin startReq = 0; irqReq = 0; ienReq = 0; end
    repeat (30) @(negedge clk);
    @(negedge clk) irqReq = 1;
    @(negedge clk) irqReq = 0;
    while (done !== 1'b1) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R9", "start wins, first is scratch write", entryOk(base, 1, 5'd16, TW), 1);
    chk("R9", "no extra transactions", logN - base, 8);
    for (int i = base; i < logN; i++)
      chk("R9", "no interrupt reads", (logReg[i] == 5'd1 || logReg[i] == 5'd17) ? 1 : 0, 0);
    chk("R9", "result", linkCode, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rstN = 1;
    repeat (2) @(negedge clk);
    t_bringup("R5 100F late link", 1, 2, 16'h3800, 4, 3);
    t_bringup("R5 10H first read", 0, 0, 16'h2000, 1, 1);
    t_bringup("R5 100H", 1, 1, 16'h2800, 3, 2);
    t_bringup("R5 10F", 0, 3, 16'h3000, 2, 4);
    t_bringup("R4 never linked", 0, 1000, 16'h0800, 0, PMAX);
    t_bringup("R5 field without bit13", 1, 0, 16'h1800, 0, 1);
    t_fault();
    t_ien(1);
    t_ien(0);
    t_bringup("R12 recovery", 1, 0, 16'h3800, 4, 1);
    t_irq(2, 16'h3000, 2);
    t_busy();
    chk("R10", "request fields held", holdErr, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule